// File: doc/BRIEF.md
# Dual Counter with Snapshot Readout

This block holds two up-counters, A and B, each advanced by its own count clock and both zeroed by one shared asynchronous active-low clear. Counter B advances only while its active-low enable is held low. Counter A raises no flag while counting, but it pulls its active-low carry output low for as long as it sits at its all-ones value. If that carry is wired to B's enable and both counters share one count clock, the pair behaves as a single counter twice as wide.

A separate register clock copies both counters into one holding register on the same edge. The held value is read out one byte at a time over a narrow bus. Each byte has its own active-low select. When no select is low, the bus is released to high impedance. When several selects are low, the lowest-numbered one wins. The clear input leaves the holding register alone, so a captured result survives a counter restart.

Top module: `dual_snap_counter`

## Requirements
- R1: While `clr_n` is low, both counters are held at zero, and this needs no clock edge. A capture taken after a clear reads zero in every byte, and `carry_a_n` is high.
- R2: Counter A adds one on each rising edge of `clk_a`. It wraps from 0xFFFF to 0x0000.
- R3: Counter B adds one on a rising edge of `clk_b` only when `cnt_b_en_n` is low at that edge. When the enable is high, B keeps its value.
- R4: `carry_a_n` is low exactly while counter A equals 0xFFFF, and high for every other value.
- R5: With `carry_a_n` tied to `cnt_b_en_n` and one clock on both count inputs, the step from A=0xFFFF, B=0 gives A=0, B=1.
- R6: A rising edge of `reg_clk` loads {B, A} into the holding register. Between such edges, counting does not change what the bus shows.
- R7: Select index 0 shows A bits 7:0, index 1 shows A bits 15:8, index 2 shows B bits 7:0 and index 3 shows B bits 15:8. A select line is active low.
- R8: When every bit of `sel_n` is high, `bus_oe` is low and `bus_out` is released to high impedance.
- R9: When several select bits are low, the lowest active index drives the bus.
- R10: `clr_n` does not change the holding register. After a clear, the bus still shows the previously captured value until the next `reg_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clr_n | input | 1 | Asynchronous active-low clear of both counters |
| clk_a | input | 1 | Count clock of counter A, rising edge |
| clk_b | input | 1 | Count clock of counter B, rising edge |
| cnt_b_en_n | input | 1 | Active-low count enable of counter B |
| reg_clk | input | 1 | Capture clock of the holding register, rising edge |
| sel_n | input | 4 | Active-low byte selects; index 0 A low, 1 A high, 2 B low, 3 B high |
| carry_a_n | output | 1 | Low while counter A is all ones |
| bus_oe | output | 1 | High while some select drives the bus |
| bus_out | output | 8 | Selected byte of the held value, bit 0 is the LSB; high impedance when idle |

## Verification
The checker watches every count edge. On each edge it confirms that A steps by one, that B steps or holds according to the enable it sampled, that an edge seen with the carry low lands A on zero, and that each capture edge loads exactly the counter values sampled at the previous capture. Some behaviours can only be shown by the bench's directed scenarios. These are the byte lane mapping, the select priority, the released bus, the cascade across the A wrap, and the holding register keeping its value through a clear.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;

  // Index of the lowest active-low request among the first n bits, or -1.
  function automatic int first_low(input logic [31:0] req_n, input int n);
    int hit;
    hit = -1;
    for (int i = n - 1; i >= 0; i--) begin
      if (!req_n[i]) hit = i;
    end
    return hit;
  endfunction

  // Number of bus lanes needed to cover a value of the given width.
  function automatic int lane_count(input int val_w, input int bus_w);
    return (val_w + bus_w - 1) / bus_w;
  endfunction

endpackage

// File: rtl/dsc_counter.sv
`timescale 1ns/1ps
module dsc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             en_n,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic step;

  // Named event wires for observation.
  assign step = ~en_n;
  assign full = &count;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    count <= '0;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/dsc_snapshot.sv
`timescale 1ns/1ps
module dsc_snapshot #(
  parameter int SNAP_W = 32
) (
  input  logic              clk,
  input  logic [SNAP_W-1:0] d,
  output logic [SNAP_W-1:0] q
);
  // Deliberately free of any reset: only a capture edge alters it.
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/dsc_bytesel.sv
`timescale 1ns/1ps
module dsc_bytesel #(
  parameter int SNAP_W = 32,
  parameter int BUS_W  = 8,
  localparam int NSEL  = SNAP_W / BUS_W,
  localparam int IDX_W = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic [SNAP_W-1:0] held,
  input  logic [NSEL-1:0]   sel_n,
  output logic              oe,
  output logic [BUS_W-1:0]  data
);
  import dsc_pkg::*;

  logic [BUS_W-1:0] lane [NSEL];
  logic [IDX_W-1:0] idx;
  int               pick;

  for (genvar g = 0; g < NSEL; g++) begin : g_lane
    assign lane[g] = held[g*BUS_W +: BUS_W];
  end

  always_comb begin
    pick = first_low(32'(sel_n), NSEL);
    oe   = (pick >= 0);
    idx  = oe ? IDX_W'(pick) : '0;
    data = lane[idx];
  end
endmodule

// File: rtl/dual_snap_counter.sv
`timescale 1ns/1ps
module dual_snap_counter #(
  parameter int CNT_W   = 16,
  parameter int BUS_W   = 8,
  localparam int SNAP_W = 2 * CNT_W,
  localparam int NSEL   = SNAP_W / BUS_W
) (
  input  logic             clr_n,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             cnt_b_en_n,
  input  logic             reg_clk,
  input  logic [NSEL-1:0]  sel_n,
  output logic             carry_a_n,
  output logic             bus_oe,
  output logic [BUS_W-1:0] bus_out
);
  logic [CNT_W-1:0]  cnt_a;
  logic [CNT_W-1:0]  cnt_b;
  logic              a_full;
  logic              b_full_unused;
  logic [SNAP_W-1:0] held;
  logic              drive;
  logic [BUS_W-1:0]  lane_val;

  dsc_counter #(.CNT_W(CNT_W)) u_cnt_a (
    .clk(clk_a), .clr_n(clr_n), .en_n(1'b0), .count(cnt_a), .full(a_full)
  );

  dsc_counter #(.CNT_W(CNT_W)) u_cnt_b (
    .clk(clk_b), .clr_n(clr_n), .en_n(cnt_b_en_n), .count(cnt_b), .full(b_full_unused)
  );

  assign carry_a_n = ~a_full;

  dsc_snapshot #(.SNAP_W(SNAP_W)) u_snap (
    .clk(reg_clk), .d({cnt_b, cnt_a}), .q(held)
  );

  dsc_bytesel #(.SNAP_W(SNAP_W), .BUS_W(BUS_W)) u_sel (
    .held(held), .sel_n(sel_n), .oe(drive), .data(lane_val)
  );

  assign bus_oe  = drive;
  assign bus_out = drive ? lane_val : {BUS_W{1'bz}};
endmodule

// File: rtl/dual_snap_counter_chk.sv
`timescale 1ns/1ps
module dual_snap_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic               clr_n,
  input logic               clk_a,
  input logic               clk_b,
  input logic               reg_clk,
  input logic               cnt_b_en_n,
  input logic               carry_a_n,
  input logic [CNT_W-1:0]   cnt_a,
  input logic [CNT_W-1:0]   cnt_b,
  input logic [2*CNT_W-1:0] held
);
  // Each flag is set once its clock has ticked since the last clear.
  logic armed_a, armed_b, armed_r;

  always_ff @(posedge clk_a or negedge clr_n)
    if (!clr_n) armed_a <= 1'b0; else armed_a <= 1'b1;
  always_ff @(posedge clk_b or negedge clr_n)
    if (!clr_n) armed_b <= 1'b0; else armed_b <= 1'b1;
  always_ff @(posedge reg_clk or negedge clr_n)
    if (!clr_n) armed_r <= 1'b0; else armed_r <= 1'b1;

  AST_A_STEP: assert property (@(posedge clk_a) disable iff (!clr_n)
    armed_a |-> cnt_a == $past(cnt_a) + 1'b1); // R2

  AST_B_COUNT: assert property (@(posedge clk_b) disable iff (!clr_n)
    (armed_b && !$past(cnt_b_en_n)) |-> cnt_b == $past(cnt_b) + 1'b1); // R3

  AST_B_HOLD: assert property (@(posedge clk_b) disable iff (!clr_n)
    (armed_b && $past(cnt_b_en_n)) |-> cnt_b == $past(cnt_b)); // R3

  AST_CARRY_WRAP: assert property (@(posedge clk_a) disable iff (!clr_n)
    (armed_a && !$past(carry_a_n)) |-> cnt_a == '0); // R4

  AST_SNAP_LOAD: assert property (@(posedge reg_clk) disable iff (!clr_n)
    armed_r |-> held == $past({cnt_b, cnt_a})); // R6
endmodule

bind dual_snap_counter dual_snap_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clr_n(clr_n), .clk_a(clk_a), .clk_b(clk_b), .reg_clk(reg_clk),
  .cnt_b_en_n(cnt_b_en_n), .carry_a_n(carry_a_n),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .held(held)
);

// File: tb/dual_snap_counter_bench.sv
`timescale 1ns/1ps
module dual_snap_counter_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic       clr_n = 1'b0;
  logic       clk_a = 1'b0;
  logic       clk_b_drv = 1'b0;
  logic       en_drv = 1'b1;
  logic       chain = 1'b0;
  logic       reg_clk = 1'b0;
  logic [3:0] sel_n = 4'hF;
  logic       clk_b, cnt_b_en_n;
  logic       carry_a_n, bus_oe;
  wire  [7:0] bus_out;

  assign clk_b      = chain ? clk_a : clk_b_drv;
  assign cnt_b_en_n = chain ? carry_a_n : en_drv;

  dual_snap_counter u_dual_snap_counter (
    .clr_n(clr_n), .clk_a(clk_a), .clk_b(clk_b), .cnt_b_en_n(cnt_b_en_n),
    .reg_clk(reg_clk), .sel_n(sel_n), .carry_a_n(carry_a_n),
    .bus_oe(bus_oe), .bus_out(bus_out)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clk_a = 1'b1; #5; clk_a = 1'b0;
    end
    #2;
  endtask

  task automatic pulse_b(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clk_b_drv = 1'b1; #5; clk_b_drv = 1'b0;
    end
    #2;
  endtask

  task automatic capture();
    @(negedge clk); reg_clk = 1'b1; #5; reg_clk = 1'b0; #2;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_n = 1'b0; #4; clr_n = 1'b1; #2;
  endtask

  task automatic read_lane(input int idx, output logic [7:0] val);
    sel_n = ~(4'b0001 << idx); #2;
    val = bus_out;
    sel_n = 4'hF; #1;
  endtask

  task automatic read_all(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      read_lane(i, b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #3; clr_n = 1'b1; #2;
    do_clear();
    capture();
    read_all(v);
    check("R1 zero after clear", v, 32'h0);
    check("R1 carry idle", 32'(carry_a_n), 32'h1);
    sel_n = 4'hF; #2;
    check("R8 bus released", 32'(bus_oe), 32'h0);
  endtask

  task automatic t_count_a();
    logic [7:0] b;
    pulse_a(261);
    capture();
    read_lane(0, b); check("R2 R7 A low byte", 32'(b), 32'h05);
    read_lane(1, b); check("R2 R7 A high byte", 32'(b), 32'h01);
  endtask

  task automatic t_count_b();
    logic [7:0] b;
    en_drv = 1'b1;
    pulse_b(5);
    capture();
    read_lane(2, b); check("R3 B held when disabled", 32'(b), 32'h00);
    en_drv = 1'b0;
    pulse_b(3);
    capture();
    read_lane(2, b); check("R3 R7 B low byte", 32'(b), 32'h03);
    read_lane(3, b); check("R7 B high byte", 32'(b), 32'h00);
    en_drv = 1'b1;
  endtask

  task automatic t_hold();
    logic [7:0] b;
    pulse_a(2);
    read_lane(0, b); check("R6 readout frozen", 32'(b), 32'h05);
  endtask

  task automatic t_priority();
    sel_n = 4'b1001; #2;
    check("R9 lanes 1,2 -> lane 1", 32'(bus_out), 32'h01);
    sel_n = 4'b0011; #2;
    check("R9 lanes 2,3 -> lane 2", 32'(bus_out), 32'h03);
    sel_n = 4'b0000; #2;
    check("R9 all lanes -> lane 0", 32'(bus_out), 32'h05);
    check("R9 drive on", 32'(bus_oe), 32'h1);
    sel_n = 4'hF; #2;
  endtask

  task automatic t_clear_hold();
    logic [7:0] b;
    do_clear();
    read_lane(0, b); check("R10 held survives clear", 32'(b), 32'h05);
    capture();
    read_lane(0, b); check("R1 counter A cleared", 32'(b), 32'h00);
    read_lane(2, b); check("R1 counter B cleared", 32'(b), 32'h00);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    chain = 1'b1; #2;
    pulse_a(65534);
    check("R4 carry high at FFFE", 32'(carry_a_n), 32'h1);
    capture(); read_all(v);
    check("R5 chain at FFFE", v, 32'h0000_FFFE);
    pulse_a(1);
    check("R4 carry low at FFFF", 32'(carry_a_n), 32'h0);
    capture(); read_all(v);
    check("R5 chain at FFFF", v, 32'h0000_FFFF);
    pulse_a(1);
    check("R4 carry high after wrap", 32'(carry_a_n), 32'h1);
    capture(); read_all(v);
    check("R2 R5 wrap carries into B", v, 32'h0001_0000);
    chain = 1'b0; #2;
  endtask

  initial begin
    t_reset();
    t_count_a();
    t_count_b();
    t_hold();
    t_priority();
    t_clear_hold();
    t_chain();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule